// File: doc/BRIEF.md
# Warp Load Coalescer

This block accepts one load request for a whole warp of 32 lanes. Each lane carries an enable bit, a byte address and an access width of 4, 8 or 16 bytes. The block groups the bytes that the enabled lanes touch by aligned 128-byte line. It then issues one downstream transaction per distinct line, one transaction at a time, over a valid/ready port.

Each transaction carries three things. The first is the line number, which is the byte address shifted right by 7. The second is a 4-bit mask of the 32-byte sectors inside the line that are touched. The third is a 32-bit mask of the lanes that take data from that line, so that a return path can steer the data back to those lanes. When every line has been handed off, the block raises a one-cycle completion strobe. The strobe carries the number of transactions and the total number of sectors used by the request.

A lane whose access is not aligned can spill past the end of a line. That lane then belongs to both lines: it touches the upper sectors of the lower line and the lower sectors of the next line.

Top module: `warp_coalescer`

## Requirements
- R1: Every transaction names a line number equal to byte address bits [31:7]. Exactly one transaction is issued for each distinct line touched by at least one enabled lane, so 32 enabled 4-byte lanes at consecutive addresses from a 128-byte boundary give one transaction.
- R2: Bit k of `txn_sectors` is set exactly when some lane of that transaction touches a byte at line offset 32*k to 32*k+31.
- R3: Bit j of `txn_lanes` is set exactly when enabled lane j touches at least one byte of that line. A transaction never carries an empty lane mask or an empty sector mask.
- R4: The width code in `req_size` (2 bits per lane, lane j at bits [2j+1:2j]) means 0 = 4 bytes, 1 = 8 bytes, 2 = 16 bytes. Lane j covers bytes addr to addr+width-1, where addr is `req_addr[32j+31:32j]`.
- R5: Transactions leave in increasing order of the lowest-numbered lane that touches each line. A lane whose bytes span two lines places its lower line before its upper line.
- R6: An access that crosses a 128-byte boundary is counted against both lines. It sets sectors from its start sector to 3 in the lower line, and sectors from 0 to its end sector in the upper line.
- R7: Disabled lanes add no transactions, sectors or lane bits. A request with no enabled lane produces no transaction and completes with both counts zero.
- R8: `done_valid` pulses for one cycle, in the cycle after the last transaction is accepted. At that pulse, `done_txns` and `done_sectors` equal the number of transactions and the sum of their sector-mask population counts.
- R9: `req_ready` is high only while no request is in progress. The first transaction, or the completion pulse for an empty request, appears in the cycle after acceptance. A transaction held with `txn_ready` low keeps all its fields unchanged.
- R10: After synchronous reset, `req_ready` is 1 and `txn_valid` and `done_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Warp request offered |
| req_ready | output | 1 | Block idle and able to take a request |
| req_active | input | 32 | Per-lane enable |
| req_addr | input | 1024 | Per-lane byte address, lane j at bits [32j+31:32j] |
| req_size | input | 64 | Per-lane width code, lane j at bits [2j+1:2j] |
| txn_valid | output | 1 | Line transaction offered |
| txn_ready | input | 1 | Downstream accepts the transaction |
| txn_line | output | 25 | Line number (address bits [31:7]) |
| txn_sectors | output | 4 | Touched 32-byte sectors of the line |
| txn_lanes | output | 32 | Lanes served by this line |
| done_valid | output | 1 | One-cycle completion strobe |
| done_txns | output | 7 | Transactions issued for the request |
| done_sectors | output | 9 | Sectors issued for the request |

## Verification
A request is taken at the rising edge where `req_valid` and `req_ready` are both high. Its first transaction is valid from the following cycle, because the line choice is made combinationally from the captured lane state. After that, each accepted transaction exposes the next one in the very next cycle. The completion strobe with final counts comes one cycle after the last acceptance. The bench drives inputs and samples outputs at the falling edge, so it observes each cycle exactly once. It decides acceptance from the `txn_ready` value it has just driven, and therefore checks each result in the cycle where it becomes due. When downstream is stalled, it compares the held fields cycle by cycle.

// File: rtl/coal_pkg.sv
package coal_pkg;

    localparam int LANES   = 32;
    localparam int AW      = 32;
    localparam int LINE_B  = 128;
    localparam int SECT_B  = 32;
    localparam int SZ_W    = 2;

    localparam int OFS_W   = $clog2(LINE_B);
    localparam int SEC_LO  = $clog2(SECT_B);
    localparam int NSEC    = LINE_B / SECT_B;
    localparam int SIDX_W  = $clog2(NSEC);
    localparam int LINE_W  = AW - OFS_W;
    localparam int PCNT_W  = $clog2(NSEC + 1);
    localparam int TXN_W   = $clog2(2 * LANES + 1);
    localparam int SCNT_W  = $clog2(2 * LANES * NSEC + 1);

    typedef enum logic [SZ_W-1:0] {
        SZ_4B    = 2'd0,
        SZ_8B    = 2'd1,
        SZ_16B   = 2'd2,
        SZ_16B_R = 2'd3
    } acc_size_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_ISSUE = 1'b1
    } coal_state_e;

    typedef struct packed {
        logic [LINE_W-1:0] line;
        logic [NSEC-1:0]   sect;
    } line_part_t;

    typedef struct packed {
        line_part_t lower;
        line_part_t upper;
        logic       crosses;
    } lane_span_t;

    // Offset of the last byte of an access from its first byte.
    function automatic logic [AW-1:0] last_ofs(acc_size_e s);
        case (s)
            SZ_4B:   return AW'(3);
            SZ_8B:   return AW'(7);
            default: return AW'(15);
        endcase
    endfunction

    function automatic logic [NSEC-1:0] sect_range(logic [SIDX_W-1:0] lo,
                                                   logic [SIDX_W-1:0] hi);
        logic [NSEC-1:0] m;
        for (int k = 0; k < NSEC; k++)
            m[k] = (SIDX_W'(k) >= lo) && (SIDX_W'(k) <= hi);
        return m;
    endfunction

    function automatic logic [PCNT_W-1:0] sect_count(logic [NSEC-1:0] m);
        logic [PCNT_W-1:0] c;
        c = '0;
        for (int k = 0; k < NSEC; k++)
            c = c + PCNT_W'(m[k]);
        return c;
    endfunction

endpackage

// File: rtl/coal_lane_span.sv
module coal_lane_span
    import coal_pkg::*;
(
    input  logic [AW-1:0] addr,
    input  acc_size_e     size,
    output lane_span_t    span
);

    logic [AW-1:0]     last_b;
    logic [SIDX_W-1:0] s_first;
    logic [SIDX_W-1:0] s_last;
    logic              unused_low;

    assign last_b     = addr + last_ofs(size);
    assign s_first    = addr[OFS_W-1:SEC_LO];
    assign s_last     = last_b[OFS_W-1:SEC_LO];
    assign unused_low = ^last_b[SEC_LO-1:0];

    always_comb begin
        span.lower.line = addr[AW-1:OFS_W];
        span.upper.line = last_b[AW-1:OFS_W];
        span.crosses    = (addr[AW-1:OFS_W] != last_b[AW-1:OFS_W]);
        span.lower.sect = sect_range(s_first,
                                     span.crosses ? SIDX_W'(NSEC - 1) : s_last);
        span.upper.sect = sect_range('0, s_last);
    end

endmodule

// File: rtl/coal_pick.sv
module coal_pick
    import coal_pkg::*;
(
    input  logic [LANES-1:0]  lo_pend,
    input  logic [LANES-1:0]  hi_pend,
    input  lane_span_t        spans [LANES],
    output logic              found,
    output logic [LINE_W-1:0] line
);

    // Lowest pending lane wins; its lower line goes before its upper line.
    always_comb begin
        found = 1'b0;
        line  = '0;
        for (int i = LANES - 1; i >= 0; i--) begin
            if (lo_pend[i] || hi_pend[i]) begin
                found = 1'b1;
                line  = lo_pend[i] ? spans[i].lower.line : spans[i].upper.line;
            end
        end
    end

endmodule

// File: rtl/coal_match.sv
module coal_match
    import coal_pkg::*;
(
    input  logic [LINE_W-1:0] line,
    input  logic [LANES-1:0]  lo_pend,
    input  logic [LANES-1:0]  hi_pend,
    input  lane_span_t        spans [LANES],
    output logic [LANES-1:0]  lo_hit,
    output logic [LANES-1:0]  hi_hit,
    output logic [NSEC-1:0]   sect,
    output logic [LANES-1:0]  lanes
);

    for (genvar g = 0; g < LANES; g++) begin : g_cmp
        assign lo_hit[g] = lo_pend[g] && (spans[g].lower.line == line);
        assign hi_hit[g] = hi_pend[g] && (spans[g].upper.line == line);
    end

    assign lanes = lo_hit | hi_hit;

    always_comb begin
        sect = '0;
        for (int i = 0; i < LANES; i++) begin
            if (lo_hit[i]) sect = sect | spans[i].lower.sect;
            if (hi_hit[i]) sect = sect | spans[i].upper.sect;
        end
    end

endmodule

// File: rtl/warp_coalescer.sv
module warp_coalescer
    import coal_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic [LANES-1:0]      req_active,
    input  logic [LANES*AW-1:0]   req_addr,
    input  logic [LANES*SZ_W-1:0] req_size,
    output logic                  txn_valid,
    input  logic                  txn_ready,
    output logic [LINE_W-1:0]     txn_line,
    output logic [NSEC-1:0]       txn_sectors,
    output logic [LANES-1:0]      txn_lanes,
    output logic                  done_valid,
    output logic [TXN_W-1:0]      done_txns,
    output logic [SCNT_W-1:0]     done_sectors
);

    coal_state_e       st_q;
    logic [AW-1:0]     addr_q [LANES];
    acc_size_e         size_q [LANES];
    lane_span_t        spans  [LANES];
    logic [LANES-1:0]  lo_q, hi_q, cross_v, hi_eff;
    logic [LANES-1:0]  lo_hit, hi_hit;
    logic [TXN_W-1:0]  txn_cnt_q;
    logic [SCNT_W-1:0] sec_cnt_q;
    logic              found, accept, fire;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        coal_lane_span u_span (
            .addr (addr_q[g]),
            .size (size_q[g]),
            .span (spans[g])
        );
        assign cross_v[g] = spans[g].crosses;
    end

    assign hi_eff = hi_q & cross_v;

    coal_pick u_pick (
        .lo_pend (lo_q),
        .hi_pend (hi_eff),
        .spans   (spans),
        .found   (found),
        .line    (txn_line)
    );

    coal_match u_match (
        .line    (txn_line),
        .lo_pend (lo_q),
        .hi_pend (hi_eff),
        .spans   (spans),
        .lo_hit  (lo_hit),
        .hi_hit  (hi_hit),
        .sect    (txn_sectors),
        .lanes   (txn_lanes)
    );

    assign req_ready    = (st_q == ST_IDLE);
    assign accept       = req_valid && req_ready;
    assign txn_valid    = (st_q == ST_ISSUE) && found;
    assign fire         = txn_valid && txn_ready;
    assign done_valid   = (st_q == ST_ISSUE) && !found;
    assign done_txns    = txn_cnt_q;
    assign done_sectors = sec_cnt_q;

    // Lane payload: captured on accept, no reset needed (gated by pend bits).
    always_ff @(posedge clk) begin
        if (accept) begin
            for (int g = 0; g < LANES; g++) begin
                addr_q[g] <= req_addr[g*AW +: AW];
                size_q[g] <= acc_size_e'(req_size[g*SZ_W +: SZ_W]);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= ST_IDLE;
            lo_q      <= '0;
            hi_q      <= '0;
            txn_cnt_q <= '0;
            sec_cnt_q <= '0;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (accept) begin
                        st_q      <= ST_ISSUE;
                        lo_q      <= req_active;
                        hi_q      <= req_active;
                        txn_cnt_q <= '0;
                        sec_cnt_q <= '0;
                    end
                end
                default: begin
                    if (fire) begin
                        lo_q      <= lo_q & ~lo_hit;
                        hi_q      <= hi_q & ~hi_hit;
                        txn_cnt_q <= txn_cnt_q + TXN_W'(1);
                        sec_cnt_q <= sec_cnt_q + SCNT_W'(sect_count(txn_sectors));
                    end
                    if (!found) begin
                        st_q <= ST_IDLE;
                        hi_q <= '0;
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/coal_chk.sv
module coal_chk
    import coal_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic              txn_valid,
    input logic              txn_ready,
    input logic [LINE_W-1:0] txn_line,
    input logic [NSEC-1:0]   txn_sectors,
    input logic [LANES-1:0]  txn_lanes,
    input logic              done_valid,
    input logic [TXN_W-1:0]  done_txns,
    input logic [SCNT_W-1:0] done_sectors
);

    logic rst_d;
    always_ff @(posedge clk) rst_d <= rst;

    p_reset_idle_r10: assert property (@(posedge clk)
        rst_d && !rst |-> req_ready && !txn_valid && !done_valid);

    p_hold_stall_r9: assert property (@(posedge clk) disable iff (rst)
        txn_valid && !txn_ready |=> txn_valid && $stable(txn_line)
                                    && $stable(txn_sectors) && $stable(txn_lanes));

    p_busy_no_ready_r9: assert property (@(posedge clk) disable iff (rst)
        txn_valid |-> !req_ready);

    p_nonempty_txn_r3: assert property (@(posedge clk) disable iff (rst)
        txn_valid |-> (txn_lanes != '0) && (txn_sectors != '0));

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        done_valid |=> !done_valid);

    p_done_alone_r8: assert property (@(posedge clk) disable iff (rst)
        done_valid |-> !txn_valid);

    p_sector_bound_r2: assert property (@(posedge clk) disable iff (rst)
        done_valid |-> (32'(done_sectors) <= 32'(done_txns) * NSEC)
                       && (32'(done_sectors) >= 32'(done_txns)));

    p_empty_zero_r7: assert property (@(posedge clk) disable iff (rst)
        done_valid && (done_txns == '0) |-> done_sectors == '0);

    p_req_held_r9: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_ready |=> !req_ready);

endmodule

bind warp_coalescer coal_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .txn_valid    (txn_valid),
    .txn_ready    (txn_ready),
    .txn_line     (txn_line),
    .txn_sectors  (txn_sectors),
    .txn_lanes    (txn_lanes),
    .done_valid   (done_valid),
    .done_txns    (done_txns),
    .done_sectors (done_sectors)
);

// File: tb/sim_warp_coalescer.sv
`timescale 1ns/1ps
module sim_warp_coalescer;
    import coal_pkg::*;

    logic                  clk = 1'b0;
    logic                  rst = 1'b1;
    logic                  req_valid = 1'b0;
    logic                  req_ready;
    logic [LANES-1:0]      req_active = '0;
    logic [LANES*AW-1:0]   req_addr = '0;
    logic [LANES*SZ_W-1:0] req_size = '0;
    logic                  txn_valid;
    logic                  txn_ready = 1'b0;
    logic [LINE_W-1:0]     txn_line;
    logic [NSEC-1:0]       txn_sectors;
    logic [LANES-1:0]      txn_lanes;
    logic                  done_valid;
    logic [TXN_W-1:0]      done_txns;
    logic [SCNT_W-1:0]     done_sectors;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    warp_coalescer u0 (.*);

    typedef struct packed {
        logic [31:0] base;
        logic [31:0] stride;
        logic [1:0]  szc;
        logic [31:0] act;
        logic [6:0]  ntx;
        logic [8:0]  nsec;
        logic        stall;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{32'h0000_1000, 32'd4,         2'd0, 32'hFFFF_FFFF, 7'd1,  9'd4,  1'b0}, // R1 coalesced
        '{32'h0000_1000, 32'd8,         2'd0, 32'hFFFF_FFFF, 7'd2,  9'd8,  1'b0}, // R1 stride 2 words
        '{32'h0000_1000, 32'd8,         2'd1, 32'hFFFF_FFFF, 7'd2,  9'd8,  1'b0}, // R4 8-byte
        '{32'h0000_1000, 32'd16,        2'd2, 32'hFFFF_FFFF, 7'd4,  9'd16, 1'b0}, // R4 16-byte
        '{32'h0000_1000, 32'd128,       2'd0, 32'hFFFF_FFFF, 7'd32, 9'd32, 1'b0}, // R1 stride 32 words
        '{32'h0000_1000, 32'd16,        2'd0, 32'hFFFF_FFFF, 7'd4,  9'd16, 1'b0}, // R2 stride 4 words
        '{32'h0000_1000, 32'd4,         2'd0, 32'h0000_0000, 7'd0,  9'd0,  1'b0}, // R7 empty
        '{32'h0000_1000, 32'd4,         2'd0, 32'h0000_0001, 7'd1,  9'd1,  1'b0}, // R7 one lane
        '{32'h0000_1078, 32'd0,         2'd2, 32'hFFFF_FFFF, 7'd2,  9'd2,  1'b0}, // R6 crossing
        '{32'h0000_1000, 32'd132,       2'd0, 32'hFFFF_FFFF, 7'd32, 9'd32, 1'b0}, // R1 scattered
        '{32'h0000_3000, 32'hFFFF_FF80, 2'd0, 32'hFFFF_FFFF, 7'd32, 9'd32, 1'b0}, // R5 descending
        '{32'h0000_1004, 32'd4,         2'd0, 32'hFFFF_FFFF, 7'd2,  9'd5,  1'b1}, // R2 offset, stall
        '{32'h0000_1000, 32'd8,         2'd1, 32'hAAAA_AAAA, 7'd2,  9'd8,  1'b1}, // R7 odd lanes
        '{32'h0000_107C, 32'd0,         2'd1, 32'h0000_0005, 7'd2,  9'd2,  1'b0}  // R6 8-byte cross
    };

    logic [LINE_W-1:0] exp_line  [64];
    logic [NSEC-1:0]   exp_sect  [64];
    logic [LANES-1:0]  exp_lanes [64];
    int                exp_n;

    task automatic check(input logic ok, input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Byte-level reference: walk every byte of every enabled lane.
    task automatic build_model(input logic [31:0] base, input logic [31:0] stride,
                               input logic [1:0] szc, input logic [31:0] act);
        exp_n = 0;
        for (int l = 0; l < LANES; l++) begin
            int nb;
            nb = (szc == 2'd0) ? 4 : (szc == 2'd1) ? 8 : 16;
            if (act[l]) begin
                for (int b = 0; b < nb; b++) begin
                    logic [31:0] a;
                    int idx;
                    a   = base + stride * l + b;
                    idx = -1;
                    for (int k = 0; k < exp_n; k++)
                        if (exp_line[k] == a[31:7]) idx = k;
                    if (idx < 0) begin
                        idx = exp_n;
                        exp_line[idx]  = a[31:7];
                        exp_sect[idx]  = '0;
                        exp_lanes[idx] = '0;
                        exp_n++;
                    end
                    exp_sect[idx][a[6:5]] = 1'b1;
                    exp_lanes[idx][l]     = 1'b1;
                end
            end
        end
    endtask

    task automatic run_vec(input vec_t v, input int vi);
        int got, cyc;
        logic prev_stall;
        logic [LINE_W-1:0] p_line;
        logic [NSEC-1:0]   p_sect;
        logic [LANES-1:0]  p_lanes;
        build_model(v.base, v.stride, v.szc, v.act);
        check(exp_n == int'(v.ntx), $sformatf("R1 vec%0d model count", vi),
              64'(exp_n), 64'(v.ntx));
        @(negedge clk);
        check(req_ready == 1'b1, "R9 ready when idle", 64'(req_ready), 64'd1);
        req_valid  = 1'b1;
        req_active = v.act;
        for (int l = 0; l < LANES; l++) begin
            req_addr[l*AW +: AW]     = v.base + v.stride * l;
            req_size[l*SZ_W +: SZ_W] = v.szc;
        end
        @(negedge clk);
        req_valid = 1'b0;
        if (v.ntx != 0)
            check(txn_valid == 1'b1, $sformatf("R9 vec%0d first txn due", vi),
                  64'(txn_valid), 64'd1);
        else
            check(done_valid == 1'b1, $sformatf("R7 vec%0d empty done due", vi),
                  64'(done_valid), 64'd1);
        got = 0;
        cyc = 0;
        prev_stall = 1'b0;
        p_line = '0; p_sect = '0; p_lanes = '0;
        while (!done_valid && cyc < 400) begin
            txn_ready = v.stall ? cyc[0] : 1'b1;
            if (prev_stall)
                check(txn_valid && txn_line == p_line && txn_sectors == p_sect
                      && txn_lanes == p_lanes, $sformatf("R9 vec%0d hold", vi),
                      64'(txn_line), 64'(p_line));
            check(!(txn_valid && req_ready), "R9 busy not ready", 64'(req_ready), 64'd0);
            if (txn_valid && txn_ready) begin
                if (got < exp_n) begin
                    check(txn_line == exp_line[got],
                          $sformatf("R1 R5 vec%0d txn%0d line", vi, got),
                          64'(txn_line), 64'(exp_line[got]));
                    check(txn_sectors == exp_sect[got],
                          $sformatf("R2 R6 vec%0d txn%0d sectors", vi, got),
                          64'(txn_sectors), 64'(exp_sect[got]));
                    check(txn_lanes == exp_lanes[got],
                          $sformatf("R3 R7 vec%0d txn%0d lanes", vi, got),
                          64'(txn_lanes), 64'(exp_lanes[got]));
                end
                got++;
            end
            prev_stall = txn_valid && !txn_ready;
            p_line = txn_line; p_sect = txn_sectors; p_lanes = txn_lanes;
            @(negedge clk);
            cyc++;
        end
        txn_ready = 1'b0;
        check(got == exp_n, $sformatf("R1 vec%0d txns seen", vi), 64'(got), 64'(exp_n));
        check(done_txns == v.ntx, $sformatf("R8 vec%0d done_txns", vi),
              64'(done_txns), 64'(v.ntx));
        check(done_sectors == v.nsec, $sformatf("R8 vec%0d done_sectors", vi),
              64'(done_sectors), 64'(v.nsec));
        @(negedge clk);
        check(done_valid == 1'b0, $sformatf("R8 vec%0d pulse ends", vi),
              64'(done_valid), 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(req_ready == 1'b1, "R10 ready in reset", 64'(req_ready), 64'd1);
        check(txn_valid == 1'b0, "R10 no txn in reset", 64'(txn_valid), 64'd0);
        rst = 1'b0;
        @(negedge clk);
        check(req_ready == 1'b1 && txn_valid == 1'b0 && done_valid == 1'b0,
              "R10 idle after reset", {61'd0, req_ready, txn_valid, done_valid}, 64'h4);
        for (int i = 0; i < NV; i++) run_vec(VECS[i], i);
        // Reset in the middle of a request returns the block to idle.
        @(negedge clk);
        req_valid = 1'b1;
        req_active = '1;
        for (int l = 0; l < LANES; l++) begin
            req_addr[l*AW +: AW]     = 32'h4000 + 32'd128 * l;
            req_size[l*SZ_W +: SZ_W] = 2'd0;
        end
        @(negedge clk);
        req_valid = 1'b0;
        check(txn_valid == 1'b1, "R9 busy before reset", 64'(txn_valid), 64'd1);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(req_ready == 1'b1 && txn_valid == 1'b0, "R10 idle after mid reset",
              {62'd0, req_ready, txn_valid}, 64'h2);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog R9 actual=hung expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule